// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests for a small microcontroller core. It holds one byte-wide control and status register. The register combines three core-source flags (timer overflow, external edge, port change) with their enable bits and two global gates. A peripheral-pending input is also merged into the request. Event pulses from the sources set their flags whether or not the source is enabled, so software can poll them. Only a software write of 0 clears a flag.

A priority-mode input selects how the two gate bits are read. With the mode off there is a single request level, and it comes out on the high output. Bit 7 is the master gate and bit 6 gates the peripheral request. With the mode on, each source has a priority-select input. Bit 7 gates the high-priority level. The low-priority level additionally needs bit 6. Both request outputs are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and both request outputs are 0. The port-change flag reset value is a parameter, 0 by default.
- R2: Register bits, from bit 7 down to bit 0, are: master/high gate, peripheral/low gate, timer enable, external enable, port enable, timer flag, external flag, port flag. A write loads all eight bits, and rd_data shows the register from the cycle after the write.
- R3: An event pulse on src_evt (bit 2 timer, bit 1 external, bit 0 port change) sets the matching flag on the next clock edge, whatever the enable and gate bits hold.
- R4: A flag is cleared only by a software write of 0 to it. If a write and an event for the same flag fall in one cycle, the flag ends up set.
- R5: With prio_mode 0, req_hi is bit 7 AND (any source whose enable and flag are both 1, OR bit 6 AND periph_pend), and req_lo is 0.
- R6: With prio_mode 1, req_hi is bit 7 AND (any enabled, flagged source whose src_hi bit is 1, OR periph_pend with periph_hi 1).
- R7: With prio_mode 1, req_lo is bit 7 AND bit 6 AND (any enabled, flagged source whose src_hi bit is 0, OR periph_pend with periph_hi 0).
- R8: The request outputs are registered. They reflect the register, mode and peripheral inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| prio_mode | input | 1 | 1 selects two priority levels |
| src_evt | input | 3 | Event pulses: bit 2 timer, bit 1 external, bit 0 port change |
| src_hi | input | 3 | Priority select per source, 1 = high |
| periph_pend | input | 1 | Peripheral interrupt pending |
| periph_hi | input | 1 | Priority of the peripheral request, 1 = high |
| req_hi | output | 1 | High-priority (or single-level) request |
| req_lo | output | 1 | Low-priority request |

## Verification
The bench fires events while the sources or gates are off. It expects the flags to set but no request to appear. A design that gated flag setting with the enables would fail here. It then sets the gates and expects the request exactly one cycle later, which catches a missing or doubled output register. It also writes 0 to a flag in the same cycle as that flag's event. A design that let the write win would lose the event. In priority mode it walks bit 6 and bit 7 against high and low sources and the peripheral. This shows any design that lets bit 6 alone release the low level, or that raises the low level with the mode off.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 3;
  localparam int REG_W   = 2 + 2 * NSRC;
  localparam int GEN_BIT = REG_W - 1;
  localparam int PEN_BIT = REG_W - 2;
  localparam int EN_LSB  = NSRC;

  // sources whose enable and flag are both set
  function automatic logic [NSRC-1:0] src_active(input logic [REG_W-1:0] r);
    return r[EN_LSB +: NSRC] & r[NSRC-1:0];
  endfunction

  // {high, low} request from register, mode and peripheral inputs
  function automatic logic [1:0] req_eval(input logic [REG_W-1:0] r,
                                          input logic pmode,
                                          input logic [NSRC-1:0] sel_hi,
                                          input logic pp, input logic pp_hi);
    logic [NSRC-1:0] act;
    logic hi, lo;
    act = src_active(r);
    if (!pmode) begin
      hi = r[GEN_BIT] & ((|act) | (r[PEN_BIT] & pp));
      lo = 1'b0;
    end else begin
      hi = r[GEN_BIT] & ((|(act & sel_hi)) | (pp & pp_hi));
      lo = r[GEN_BIT] & r[PEN_BIT] & ((|(act & ~sel_hi)) | (pp & ~pp_hi));
    end
    return {hi, lo};
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank import irq_pkg::*; #(
  parameter logic PCF_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NSRC-1:0]  evt,
  output logic [REG_W-1:0] reg_q
);
  localparam int CTRL_W = REG_W - NSRC;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NSRC-1:0]   flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data[REG_W-1:NSRC];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    localparam logic RST_V = (i == 0) ? PCF_RST : 1'b0;
    logic f_q;
    logic f_sw;
    assign f_sw = wr_en ? wr_data[i] : f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= RST_V;
      else        f_q <= f_sw | evt[i];
    end
    assign flag_q[i] = f_q;
  end

  assign reg_q = {ctrl_q, flag_q};
endmodule

// File: rtl/irq_req_logic.sv
module irq_req_logic import irq_pkg::*; (
  input  logic [REG_W-1:0] reg_q,
  input  logic             prio_mode,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             periph_pend,
  input  logic             periph_hi,
  output logic [NSRC-1:0]  active,
  output logic             hi_d,
  output logic             lo_d
);
  logic [1:0] req;
  assign active = src_active(reg_q);
  assign req    = req_eval(reg_q, prio_mode, src_hi, periph_pend, periph_hi);
  assign hi_d   = req[1];
  assign lo_d   = req[0];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irq_pkg::*; #(
  parameter logic PCF_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             prio_mode,
  input  logic [NSRC-1:0]  src_evt,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             periph_pend,
  input  logic             periph_hi,
  output logic             req_hi,
  output logic             req_lo
);
  logic [REG_W-1:0] reg_q;
  logic [NSRC-1:0]  active;
  logic             hi_d, lo_d;

  irq_flag_bank #(.PCF_RST(PCF_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt(src_evt), .reg_q(reg_q)
  );

  irq_req_logic u_req (
    .reg_q(reg_q), .prio_mode(prio_mode), .src_hi(src_hi),
    .periph_pend(periph_pend), .periph_hi(periph_hi),
    .active(active), .hi_d(hi_d), .lo_d(lo_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_hi <= 1'b0;
      req_lo <= 1'b0;
    end else begin
      req_hi <= hi_d;
      req_lo <= lo_d;
    end
  end

  assign rd_data = reg_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk import irq_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             prio_mode,
  input logic [NSRC-1:0]  src_evt,
  input logic             req_hi,
  input logic             req_lo
);
  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R3
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[i] |=> rd_data[i]);
    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[i] && !wr_en) |=> rd_data[i]);
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[REG_W-1:NSRC] == $past(wr_data[REG_W-1:NSRC]));

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[GEN_BIT] |=> (!req_hi && !req_lo));

  // R5
  single_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_mode |=> !req_lo);

  // R7
  low_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[PEN_BIT] |=> !req_lo);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .prio_mode(prio_mode), .src_evt(src_evt),
  .req_hi(req_hi), .req_lo(req_lo)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       prio_mode = 1'b0;
  logic [2:0] src_evt = '0;
  logic [2:0] src_hi = '0;
  logic       periph_pend = 1'b0;
  logic       periph_hi = 1'b0;
  logic       req_hi, req_lo;

  int nvec = 0;
  int nfail = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_reg = '0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prio_mode(prio_mode), .src_evt(src_evt),
    .src_hi(src_hi), .periph_pend(periph_pend), .periph_hi(periph_hi),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  // bench-side request model, per source walk
  function automatic logic [1:0] model_req(input logic [7:0] r, input logic pm,
                                           input logic [2:0] sh, input logic pp,
                                           input logic ph);
    logic h = 1'b0;
    logic l = 1'b0;
    for (int s = 0; s < 3; s++) begin
      if (r[s + 3] && r[s]) begin
        if (!pm || sh[s]) h = 1'b1;
        else              l = 1'b1;
      end
    end
    if (pp) begin
      if (!pm)      h = h | r[6];
      else if (ph)  h = 1'b1;
      else          l = 1'b1;
    end
    h = h & r[7];
    l = l & r[7] & r[6] & pm;
    return {h, l};
  endfunction

  task automatic step(input logic wr, input logic [7:0] wd, input logic [2:0] ev,
                      input logic [2:0] sh, input logic pm, input logic pp,
                      input logic ph, input string tag);
    logic [1:0] rq;
    logic [7:0] nx;
    @(negedge clk);
    wr_en = wr; wr_data = wd; src_evt = ev; src_hi = sh;
    prio_mode = pm; periph_pend = pp; periph_hi = ph;
    rq = model_req(m_reg, pm, sh, pp, ph);
    nx = wr ? {wd[7:3], m_reg[2:0]} : m_reg;
    for (int s = 0; s < 3; s++) nx[s] = (wr ? wd[s] : m_reg[s]) | ev[s];
    m_reg = nx;
    exp_q.push_back({nx, rq});
    tag_q.push_back(tag);
  endtask

  // monitor: compare one expected item per clock
  initial begin
    logic [9:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        nvec++;
        if (rd_data !== e[9:2] || req_hi !== e[1] || req_lo !== e[0]) begin
          nfail++;
          $display("FAIL %s: got rd=%h hi=%b lo=%b expected rd=%h hi=%b lo=%b",
                   t, rd_data, req_hi, req_lo, e[9:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    nvec++;
    if (rd_data !== 8'h00 || req_hi !== 1'b0 || req_lo !== 1'b0) begin
      nfail++;
      $display("FAIL R1 reset: got rd=%h hi=%b lo=%b expected rd=00 hi=0 lo=0",
               rd_data, req_hi, req_lo);
    end
    // single-level mode
    step(1, 8'h38, 3'b000, 3'b000, 0, 0, 0, "R2 write enables");
    step(0, 8'h00, 3'b100, 3'b000, 0, 0, 0, "R3 timer flag while gate off");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R5 masked no request");
    step(1, 8'hBC, 3'b000, 3'b000, 0, 0, 0, "R2 master gate on");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R8 request one cycle after gate");
    step(1, 8'hB8, 3'b000, 3'b000, 0, 0, 0, "R4 software clear");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R4 cleared flag drops request");
    step(1, 8'hB8, 3'b010, 3'b000, 0, 0, 0, "R4 event wins over clear");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R5 external request");
    step(1, 8'h80, 3'b001, 3'b000, 0, 0, 0, "R3 port flag while disabled");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R5 disabled source no request");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R5 peripheral needs bit6");
    step(1, 8'hC0, 3'b000, 3'b000, 0, 1, 0, "R2 peripheral gate on");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R5 peripheral request");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, "R8 peripheral request held");
    // priority mode, timer high, others low
    step(1, 8'hB8, 3'b000, 3'b100, 1, 0, 0, "R2 priority setup");
    step(0, 8'h00, 3'b010, 3'b100, 1, 0, 0, "R7 low source flagged");
    step(0, 8'h00, 3'b000, 3'b100, 1, 0, 0, "R7 low blocked by bit6");
    step(0, 8'h00, 3'b100, 3'b100, 1, 0, 0, "R6 high source flagged");
    step(0, 8'h00, 3'b000, 3'b100, 1, 0, 0, "R6 high request");
    step(1, 8'hFE, 3'b000, 3'b100, 1, 0, 0, "R7 low gate on");
    step(0, 8'h00, 3'b000, 3'b100, 1, 0, 0, "R7 both levels");
    step(1, 8'h7E, 3'b000, 3'b100, 1, 0, 0, "R7 bit7 off");
    step(0, 8'h00, 3'b000, 3'b100, 1, 0, 0, "R6 bit7 gates both");
    step(1, 8'hC0, 3'b000, 3'b100, 1, 1, 1, "R6 peripheral high setup");
    step(0, 8'h00, 3'b000, 3'b100, 1, 1, 1, "R6 peripheral high request");
    step(0, 8'h00, 3'b000, 3'b100, 1, 1, 0, "R7 peripheral low request");
    step(1, 8'h80, 3'b000, 3'b100, 1, 1, 0, "R7 peripheral low gate off");
    step(0, 8'h00, 3'b000, 3'b100, 1, 1, 0, "R7 peripheral low blocked");
    step(1, 8'hC0, 3'b000, 3'b100, 1, 1, 0, "R7 peripheral low gate back");
    step(0, 8'h00, 3'b000, 3'b100, 0, 1, 0, "R5 mode off no low level");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, "R8 drop after peripheral idle");
    @(negedge clk);
    wr_en = 1'b0; src_evt = '0; periph_pend = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule